// File: doc/BRIEF.md
# Two-Phase Multiplexed Gamepad Reader

This block reads two simple game controllers. Each controller sits on a 7-line port. Six of the lines carry button levels into the reader, and one select line is driven by the reader. The select line chooses which group of buttons appears on the shared lines. When the reader is told to poll, it handles pad 0 and then pad 1. For each pad it drives the select line low, waits a settle time and captures the port. It then drives the select line high, waits again and captures the port a second time.

The two captures are folded into one 8-bit button byte. The pins read 0 while a button is held, so the byte is inverted to be active-high. The reader keeps the previous byte of each pad and uses it to produce a second byte. That byte holds only the buttons that went from released to held since the last poll. After both pads are updated, a one-cycle valid pulse marks fresh results. When idle, both select lines rest high.

Top module: `pad_pair_reader`

## Requirements
- R1: After reset, all four button bytes are 0x00, `valid` is low and both select outputs are high.
- R2: While idle, both select outputs are high. A poll drives pad 0's select low for exactly SETTLE cycles, then high for SETTLE cycles. It then drives pad 1's select low for SETTLE cycles, then high for SETTLE cycles. The two selects are never low at the same time.
- R3: Port bit order is bit 6 select readback, bit 5 line TR, bit 4 line TL, and bits 3..0 data lines 3..0. In the select-low capture, TR gives button bit 7 (Start) and TL gives button bit 6 (A). Bits 6 and 3..0 of that capture have no effect.
- R4: In the select-high capture, TR gives bit 5 (C), TL gives bit 4 (B), and data lines 3..0 give bits 3..0 (Right, Left, Down, Up). Bit 6 of that capture has no effect.
- R5: A pin level of 0 means pressed and reports as 1 in the current byte.
- R6: The newly-pressed byte of a pad is (previous current byte XOR new current byte) AND new current byte. Each pad keeps its own previous byte.
- R7: The previous byte of both pads is 0x00 after reset, so a button held at the first poll shows as newly pressed.
- R8: `valid` is a one-cycle pulse. It rises 4*SETTLE cycles after the clock edge that accepted `poll_req`, with both pads already updated.
- R9: A `poll_req` raised while a poll is in progress is ignored. No extra poll and no extra `valid` pulse follow.
- R10: Between polls, the button bytes hold their values whatever the pins do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| poll_req | input | 1 | Start a poll of both pads (accepted when idle) |
| pad0_pins | input | 7 | Port 0 lines: [6] select readback, [5] TR, [4] TL, [3:0] data |
| pad1_pins | input | 7 | Port 1 lines, same layout |
| pad0_sel | output | 1 | Select line driven to port 0 |
| pad1_sel | output | 1 | Select line driven to port 1 |
| pad0_held | output | 8 | Pad 0 current buttons, active-high |
| pad0_fresh | output | 8 | Pad 0 newly-pressed buttons |
| pad1_held | output | 8 | Pad 1 current buttons, active-high |
| pad1_fresh | output | 8 | Pad 1 newly-pressed buttons |
| valid | output | 1 | One-cycle pulse when both pads are updated |

## Verification
A sequencer that loses its place shows at once on the select pins. The low window can have the wrong length, sit on the wrong pad, or fall on both pads. The `valid` pulse can also arrive off its 4*SETTLE slot within the same poll. A stale or crossed previous byte does not show until the next poll. It shows there as a wrong newly-pressed byte, so the bench runs polls back to back with changing buttons. A wrong capture phase or bit mapping moves a single button to the wrong output bit in the same poll. Directed one-hot patterns and random junk on the masked bits expose it.

// File: rtl/pad_rd_pkg.sv
package pad_rd_pkg;
   localparam int PORT_W = 7;
   localparam int BTN_W  = 8;

   typedef enum logic [1:0] {
      SEQ_IDLE = 2'd0,
      SEQ_LO   = 2'd1,
      SEQ_HI   = 2'd2
   } seq_st_t;

   // fold select-low and select-high captures into an active-high byte
   function automatic logic [BTN_W-1:0] fold_phases(
      input logic [PORT_W-1:0] lo_cap,
      input logic [PORT_W-1:0] hi_cap);
      logic [BTN_W-1:0] lo_part;
      logic [BTN_W-1:0] hi_part;
      lo_part = {lo_cap[5:4], 6'b000000};
      hi_part = {2'b00, hi_cap[5:0]};
      return ~(lo_part | hi_part);
   endfunction
endpackage

// File: rtl/pad_settle_timer.sv
module pad_settle_timer #(
   parameter int SETTLE = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   output logic hit
);
   localparam int CNT_W = $clog2(SETTLE) + 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE - 1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt_q <= '0;
      else if (clr) cnt_q <= '0;
      else          cnt_q <= cnt_q + 1'b1;
   end

   assign hit = (cnt_q == LAST);

   // counter never runs past the settle limit
   assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LAST);
endmodule

// File: rtl/pad_state_track.sv
module pad_state_track
   import pad_rd_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [BTN_W-1:0] cur_in,
   output logic [BTN_W-1:0] held,
   output logic [BTN_W-1:0] fresh
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held  <= '0;
         fresh <= '0;
      end else if (load) begin
         fresh <= (held ^ cur_in) & cur_in;
         held  <= cur_in;
      end
   end

   // newly-pressed bits are always a subset of held bits
   assert_fresh_subset_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (fresh & ~held) == '0);
   // outputs hold between loads
   assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> ($stable(held) && $stable(fresh)));
endmodule

// File: rtl/pad_pair_reader.sv
module pad_pair_reader
   import pad_rd_pkg::*;
#(
   parameter int SETTLE = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             poll_req,
   input  logic [PORT_W-1:0] pad0_pins,
   input  logic [PORT_W-1:0] pad1_pins,
   output logic             pad0_sel,
   output logic             pad1_sel,
   output logic [BTN_W-1:0] pad0_held,
   output logic [BTN_W-1:0] pad0_fresh,
   output logic [BTN_W-1:0] pad1_held,
   output logic [BTN_W-1:0] pad1_fresh,
   output logic             valid
);
   localparam int NUM_PADS = 2;
   localparam int IDX_W    = $clog2(NUM_PADS);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_PADS - 1);

   if (SETTLE < 1) begin : g_bad_settle
      $error("SETTLE must be at least 1");
   end

   seq_st_t          st_q;
   logic [IDX_W-1:0] idx_q;
   logic [PORT_W-1:0] lo_cap_q;
   logic             hit;
   logic             tmr_clr;
   logic             valid_q;

   logic [PORT_W-1:0] pins_arr [NUM_PADS];
   logic [BTN_W-1:0]  held_arr [NUM_PADS];
   logic [BTN_W-1:0]  fresh_arr[NUM_PADS];
   logic [NUM_PADS-1:0] sel_vec;
   logic [NUM_PADS-1:0] load_vec;
   logic [BTN_W-1:0]  merged;

   assign pins_arr[0] = pad0_pins;
   assign pins_arr[1] = pad1_pins;

   assign tmr_clr = (st_q == SEQ_IDLE) || hit;

   pad_settle_timer #(.SETTLE(SETTLE)) u_timer (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (tmr_clr),
      .hit  (hit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= SEQ_IDLE;
         idx_q    <= '0;
         lo_cap_q <= '0;
         valid_q  <= 1'b0;
      end else begin
         valid_q <= 1'b0;
         case (st_q)
            SEQ_IDLE: if (poll_req) begin
               st_q  <= SEQ_LO;
               idx_q <= '0;
            end
            SEQ_LO: if (hit) begin
               lo_cap_q <= pins_arr[idx_q];
               st_q     <= SEQ_HI;
            end
            SEQ_HI: if (hit) begin
               if (idx_q == LAST_IDX) begin
                  st_q    <= SEQ_IDLE;
                  valid_q <= 1'b1;
               end else begin
                  idx_q <= idx_q + 1'b1;
                  st_q  <= SEQ_LO;
               end
            end
            default: st_q <= SEQ_IDLE;
         endcase
      end
   end

   assign merged = fold_phases(lo_cap_q, pins_arr[idx_q]);

   for (genvar i = 0; i < NUM_PADS; i++) begin : g_pad
      assign sel_vec[i]  = !((st_q == SEQ_LO) && (idx_q == IDX_W'(i)));
      assign load_vec[i] = (st_q == SEQ_HI) && hit && (idx_q == IDX_W'(i));
      pad_state_track u_track (
         .clk   (clk),
         .rst_n (rst_n),
         .load  (load_vec[i]),
         .cur_in(merged),
         .held  (held_arr[i]),
         .fresh (fresh_arr[i])
      );
   end

   assign pad0_sel   = sel_vec[0];
   assign pad1_sel   = sel_vec[1];
   assign pad0_held  = held_arr[0];
   assign pad0_fresh = fresh_arr[0];
   assign pad1_held  = held_arr[1];
   assign pad1_fresh = fresh_arr[1];
   assign valid      = valid_q;

   assert_one_sel_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(~sel_vec) <= 1);
   assert_valid_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      valid |=> !valid);
   assert_valid_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      valid |-> (&sel_vec));
   assert_one_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(load_vec));
endmodule

// File: tb/pad_pair_reader_tb.sv
module pad_pair_reader_tb;
   localparam int S = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       poll_req = 1'b0;
   logic [6:0] pad0_pins, pad1_pins;
   logic       pad0_sel, pad1_sel, valid;
   logic [7:0] pad0_held, pad0_fresh, pad1_held, pad1_fresh;

   logic [7:0] btn0 = 8'h00, btn1 = 8'h00;
   logic [6:0] junk0 = 7'h00, junk1 = 7'h00;
   logic [7:0] prev0 = 8'h00, prev1 = 8'h00;
   int total = 0;
   int bad = 0;

   always #5 clk = ~clk;

   pad_pair_reader #(.SETTLE(S)) u_dut (
      .clk(clk), .rst_n(rst_n), .poll_req(poll_req),
      .pad0_pins(pad0_pins), .pad1_pins(pad1_pins),
      .pad0_sel(pad0_sel), .pad1_sel(pad1_sel),
      .pad0_held(pad0_held), .pad0_fresh(pad0_fresh),
      .pad1_held(pad1_held), .pad1_fresh(pad1_fresh),
      .valid(valid)
   );

   // controller model: pins low when pressed; junk on lines the reader must ignore
   function automatic logic [6:0] pin_model(input logic [7:0] b, input logic sel,
                                            input logic [6:0] j);
      if (!sel) return {j[6], ~b[7], ~b[6], j[3:0]};
      return {j[6], ~b[5], ~b[4], ~b[3:0]};
   endfunction

   function automatic logic [7:0] edge_of(input logic [7:0] p, input logic [7:0] c);
      return (p ^ c) & c;
   endfunction

   always_comb pad0_pins = pin_model(btn0, pad0_sel, junk0);
   always_comb pad1_pins = pin_model(btn1, pad1_sel, junk1);

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic do_poll(input logic [7:0] b0, input logic [7:0] b1, input bit poke);
      int n;
      int vn;
      int sel_err;
      logic [7:0] e0, e1, f0, f1;
      btn0 = b0; btn1 = b1;
      junk0 = 7'($urandom); junk1 = 7'($urandom);
      e0 = b0; e1 = b1;
      f0 = edge_of(prev0, e0); f1 = edge_of(prev1, e1);
      @(negedge clk) poll_req = 1'b1;
      @(posedge clk);
      n = 0; vn = 0; sel_err = 0;
      while (vn == 0 && n < 4*S + 6) begin
         @(negedge clk);
         n++;
         if (n == 1) poll_req = 1'b0;
         if (poke && n == 3) poll_req = 1'b1;
         if (poke && n == 4) poll_req = 1'b0;
         if (valid) vn = n;
         else if (pad0_sel != !(n >= 1 && n <= S) ||
                  pad1_sel != !(n >= 2*S+1 && n <= 3*S)) sel_err++;
      end
      chk(sel_err == 0, "R2 select sequence", 32'(sel_err), 0);
      chk(vn == 4*S + 1, "R8 valid timing", 32'(vn), 32'(4*S + 1));
      chk(pad0_held == e0, "R3/R4/R5 pad0 held", pad0_held, e0);
      chk(pad1_held == e1, "R3/R4/R5 pad1 held", pad1_held, e1);
      chk(pad0_fresh == f0, "R6 pad0 fresh", pad0_fresh, f0);
      chk(pad1_fresh == f1, "R6 pad1 fresh", pad1_fresh, f1);
      prev0 = e0; prev1 = e1;
      @(negedge clk);
      chk(!valid, "R8 valid one cycle", valid, 0);
      if (poke) begin
         int extra = 0;
         for (int k = 0; k < 4*S + 4; k++) begin
            @(negedge clk);
            if (valid || !pad0_sel || !pad1_sel) extra++;
         end
         chk(extra == 0, "R9 busy poll ignored", 32'(extra), 0);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(pad0_held == 0 && pad1_held == 0, "R1 held reset", {pad0_held, pad1_held}, 0);
      chk(pad0_fresh == 0 && pad1_fresh == 0, "R1 fresh reset", {pad0_fresh, pad1_fresh}, 0);
      chk(pad0_sel && pad1_sel && !valid, "R1 sel/valid reset",
          {pad0_sel, pad1_sel, valid}, 3'b110);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(pad0_sel && pad1_sel, "R2 idle select high", {pad0_sel, pad1_sel}, 2'b11);
      // R7: held at first poll shows as fresh
      do_poll(8'h81, 8'h42, 1'b0);
      // R3/R4 one-hot walks, pads differ
      for (int b = 0; b < 8; b++) do_poll(8'(1 << b), 8'(8'h80 >> b), 1'b0);
      do_poll(8'hFF, 8'h00, 1'b0);
      do_poll(8'hFF, 8'hFF, 1'b0);
      do_poll(8'h0F, 8'hF0, 1'b1);
      // R10: pins change between polls
      btn0 = 8'h5A; btn1 = 8'hA5; junk0 = 7'h7F; junk1 = 7'h00;
      repeat (5) @(negedge clk);
      chk(pad0_held == prev0 && pad1_held == prev1, "R10 held stable",
          {pad0_held, pad1_held}, {prev0, prev1});
      // random polls
      for (int r = 0; r < 40; r++) do_poll(8'($urandom), 8'($urandom), (r % 7) == 3);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule